// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This block holds four byte-wide registers at offsets 0 to 3 of one small I/O window. All four are reached through a single write strobe, a 2-bit offset, a write byte and a read byte. A 16-bit prescaler advances on every system clock. Its upper byte is readable as the divider, and any write to the divider offset clears the whole prescaler. A programmable 8-bit counter advances on ticks taken from one of four prescaler taps. When the counter passes 0xFF it is reloaded from a modulo register, and the block raises a one-cycle interrupt request.

The counter's control is a two-state machine. In `CNT_OFF` the counter holds its value. In `CNT_ON` a rate tick advances the counter. There are two transitions. *Enable*, `CNT_OFF` to `CNT_ON`, occurs when a control write has bit 2 set. *Disable*, `CNT_ON` to `CNT_OFF`, occurs when a control write has bit 2 clear. Inside `CNT_ON`, a tick on a counter value of 0xFF takes the *reload* path; any other tick takes the *increment* path. A CPU write to the counter overrides both paths in either state.

Reads are combinational from the offset. Writes take effect on the next rising clock edge.

Top module: `sys_timer`

## Requirements
- R1: After reset the divider, counter and modulo registers read 0x00, the control register reads 0xF8 and `irq` is low.
- R2: Offset 0 reads bits 15:8 of a 16-bit prescaler that advances by one on every clock, so the divider rises by one every 256 clocks.
- R3: Any write to offset 0 clears all 16 prescaler bits, whatever the data. No counter tick occurs on that edge.
- R4: Control register (offset 3) bits 1:0 set the counter period. The encoding is 00 for 1024 clocks, 01 for 16, 10 for 64 and 11 for 256. A tick happens on the edge where the prescaler becomes a multiple of the period.
- R5: A tick while the counter (offset 1) holds 0xFF loads the counter from the modulo register (offset 2).
- R6: `irq` goes high for exactly one cycle, starting at the edge of a reload, and at no other time.
- R7: With control bit 2 clear, the counter keeps its value, and control bit 2 reads back 0.
- R8: A counter write on the same edge as a tick stores the written byte. No increment, no reload and no `irq` occur.
- R9: Control bits 7:3 always read as 1. Counter, modulo and control bits 2:0 read back the values written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register offset: 0 divider, 1 counter, 2 modulo, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at `addr` |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
The hardest case to reach is a counter write that lands exactly on a tick edge, in particular a tick that would also overflow. The tick phase runs freely and cannot be observed directly. The stimulus therefore fixes the phase itself. It writes the control register, then the counter, then clears the divider, which leaves the prescaler at a known zero. It then waits a counted number of edges so that the next counter write coincides with the tick. The same phase alignment gives exact expected counts for each of the four rate codes and exact reload and `irq` cycles.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CNT_OFF = 1'b0,
        CNT_ON  = 1'b1
    } cnt_state_e;

    // Highest prescaler bit of each rate tap; the period is 2**(msb+1).
    function automatic int tap_msb(input int code);
        case (code)
            0:       return 9;   // 1024 clocks
            1:       return 3;   // 16 clocks
            2:       return 5;   // 64 clocks
            default: return 7;   // 256 clocks
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [PRE_W-1:0] pre_o
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else          pre_q <= pre_q + PRE_W'(1);
    end

    assign pre_o = pre_q;

    p_div_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre_q == '0);

    p_pre_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> pre_q == $past(pre_q) + PRE_W'(1));

endmodule

// File: rtl/tmr_rate_tap.sv
module tmr_rate_tap
    import sys_timer_pkg::*;
#(
    parameter int TAP_W = 10
) (
    input  logic [TAP_W-1:0] pre_lo,
    input  logic [1:0]       rate,
    input  logic             clr,
    output logic             tick
);
    logic [3:0] cand;

    // Tick condition: the low bits of the tap are all ones, so the
    // prescaler becomes a multiple of the period at the coming edge.
    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int T = tap_msb(g);
        assign cand[g] = &pre_lo[T:0];
    end

    assign tick = cand[rate] & ~clr;

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import sys_timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         en_val,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt_o,
    output logic         running_o,
    output logic         irq_o
);
    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         irq_q, irq_d;

    // State register: enable and disable transitions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (en_wr) state_d = en_val ? CNT_ON : CNT_OFF;
    end

    // Output process: increment, reload and CPU override.
    always_comb begin
        cnt_d = cnt_q;
        irq_d = 1'b0;
        unique case (state_q)
            CNT_OFF: ;
            CNT_ON: begin
                if (tick) begin
                    if (cnt_q == '1) begin
                        cnt_d = reload;
                        irq_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + W'(1);
                    end
                end
            end
        endcase
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
            irq_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = (state_q == CNT_ON);
    assign irq_o     = irq_q;

    p_reload_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> cnt_q == $past(reload));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    p_irq_from_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(tick));

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_OFF && !cnt_wr) |=> cnt_q == $past(cnt_q));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)) && !irq_q);

endmodule

// File: rtl/sys_timer.sv
module sys_timer
    import sys_timer_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int DIV_W = 8,
    parameter int TAP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CTL_PAD = DATA_W - 3;

    reg_sel_e          sel;
    logic              wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [PRE_W-1:0]  pre;
    logic [1:0]        rate_q;
    logic [DATA_W-1:0] mod_q;
    logic [DATA_W-1:0] cnt;
    logic              running;
    logic              tick;

    assign sel    = reg_sel_e'(addr);
    assign wr_div = wr_en && (sel == REG_DIV);
    assign wr_cnt = wr_en && (sel == REG_CNT);
    assign wr_mod = wr_en && (sel == REG_MOD);
    assign wr_ctl = wr_en && (sel == REG_CTL);

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_div),
        .pre_o (pre)
    );

    tmr_rate_tap #(.TAP_W(TAP_W)) u_tap (
        .pre_lo (pre[TAP_W-1:0]),
        .rate   (rate_q),
        .clr    (wr_div),
        .tick   (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= 2'b00;
            mod_q  <= '0;
        end else begin
            if (wr_ctl) rate_q <= wdata[1:0];
            if (wr_mod) mod_q  <= wdata;
        end
    end

    tmr_count_fsm #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (wr_ctl),
        .en_val    (wdata[2]),
        .tick      (tick),
        .cnt_wr    (wr_cnt),
        .cnt_wdata (wdata),
        .reload    (mod_q),
        .cnt_o     (cnt),
        .running_o (running),
        .irq_o     (irq)
    );

    always_comb begin
        unique case (sel)
            REG_DIV: rdata = pre[PRE_W-1 -: DIV_W];
            REG_CNT: rdata = cnt;
            REG_MOD: rdata = mod_q;
            REG_CTL: rdata = {{CTL_PAD{1'b1}}, running, rate_q};
        endcase
    end

    p_mod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mod |=> mod_q == $past(mod_q));

endmodule

// File: tb/tb_sys_timer.sv
module tb_sys_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;
    event done_ev;

    always #4 clk = ~clk;

    sys_timer dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    // Monitor: pops the expected item and compares with the read port.
    initial begin
        forever begin
            @(sample_ev);
            begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, rdata, it.exp);
                end
            end
            -> done_ev;
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        addr = a;
        #1;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        @(done_ev);
    endtask

    task automatic check_val(input int act, input int e, input string tag);
        checks++;
        if (act != e) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Leaves the prescaler at zero with the counter at start.
    task automatic arm(input logic [7:0] ctl, input logic [7:0] start);
        bus_write(2'd3, ctl);
        bus_write(2'd1, start);
        bus_write(2'd0, 8'h5A);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        wait_edges(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg(2'd0, 8'h00, "R1 divider");
        expect_reg(2'd1, 8'h00, "R1 counter");
        @(negedge clk);
        expect_reg(2'd2, 8'h00, "R1 modulo");
        expect_reg(2'd3, 8'hF8, "R1 control");
        check_val(irq, 0, "R1 irq");
        @(negedge clk);

        // R2 divider rate
        bus_write(2'd0, 8'h00);
        wait_edges(773);
        expect_reg(2'd0, 8'h03, "R2 divider after 773 clocks");
        // R3 clear with arbitrary data clears all prescaler bits
        bus_write(2'd0, 8'hA5);
        expect_reg(2'd0, 8'h00, "R3 divider cleared");
        wait_edges(255);
        expect_reg(2'd0, 8'h00, "R3 low bits cleared");
        wait_edges(1);
        expect_reg(2'd0, 8'h01, "R3 divider after 256");

        // R4 rate codes
        bus_write(2'd2, 8'h00);
        arm(8'h05, 8'h10);
        wait_edges(100);
        expect_reg(2'd1, 8'h16, "R4 rate 01 period 16");
        arm(8'h06, 8'h20);
        wait_edges(300);
        expect_reg(2'd1, 8'h24, "R4 rate 10 period 64");
        arm(8'h07, 8'h30);
        wait_edges(600);
        expect_reg(2'd1, 8'h32, "R4 rate 11 period 256");
        arm(8'h04, 8'h40);
        wait_edges(2100);
        expect_reg(2'd1, 8'h42, "R4 rate 00 period 1024");

        // R7 disabled counter holds
        arm(8'h01, 8'h55);
        wait_edges(500);
        expect_reg(2'd1, 8'h55, "R7 counter held");
        expect_reg(2'd3, 8'hF9, "R7 enable bit reads 0");
        @(negedge clk);

        // R5 and R6 overflow reload and interrupt
        bus_write(2'd2, 8'h80);
        expect_reg(2'd2, 8'h80, "R9 modulo readback");
        arm(8'h05, 8'hFE);
        base = irq_seen;
        wait_edges(16);
        expect_reg(2'd1, 8'hFF, "R5 counter reaches FF");
        check_val(irq, 0, "R6 no irq before overflow");
        wait_edges(16);
        expect_reg(2'd1, 8'h80, "R5 reload from modulo");
        check_val(irq, 1, "R6 irq on reload edge");
        wait_edges(1);
        check_val(irq, 0, "R6 irq one cycle");
        wait_edges(15);
        expect_reg(2'd1, 8'h81, "R5 counts on after reload");
        check_val(irq_seen - base, 1, "R6 irq pulse count");

        // R8 CPU write wins over a same-edge tick
        arm(8'h05, 8'h00);
        wait_edges(15);
        bus_write(2'd1, 8'h40);
        expect_reg(2'd1, 8'h40, "R8 write beats increment");
        wait_edges(16);
        expect_reg(2'd1, 8'h41, "R8 next tick increments");
        arm(8'h05, 8'hFF);
        base = irq_seen;
        wait_edges(15);
        bus_write(2'd1, 8'h22);
        expect_reg(2'd1, 8'h22, "R8 write beats reload");
        wait_edges(2);
        check_val(irq_seen - base, 0, "R8 no irq on overridden overflow");

        // R9 control readback
        bus_write(2'd3, 8'h00);
        expect_reg(2'd3, 8'hF8, "R9 control upper ones");
        bus_write(2'd3, 8'h07);
        expect_reg(2'd3, 8'hFF, "R9 control all set");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule